// File: doc/BRIEF.md
# Bus and Parity Error Trap Flag Unit

This block keeps the sticky status flags that record failed memory cycles: one flag for a bus error reported by the external bus and one for a parity error reported by the data-check logic. A fault that is accepted sets its flag and the general interrupt flag, and it raises a trap request. While either error flag is set, later bus and parity faults are masked. Both error flags come out of reset already set, so faults are masked until software clears them through the control-write port. An enabled external interrupt also sets the interrupt flag.

The unit also reports whether the failing access was a supervisor-mode access. The privilege mode of every issued memory cycle is queued in issue order. It is dequeued when that cycle's data-ready strobe arrives. If a fault is accepted in the clock of a data-ready strobe, or in the clock after one, the mode of that completing cycle is stored in the supervisor-error flag. The mode is captured even when the processor is in user mode by the time the fault arrives.

Top module: `err_trap_flags`

## Requirements
- R1: After reset, the parity flag and the bus flag are 1. The interrupt flag, the supervisor-error flag and the trap request are 0.
- R2: While the parity flag or the bus flag is set (after any clear in the same clock), a bus or parity fault raises no trap and changes no flag.
- R3: An unmasked bus fault sets the bus flag and the interrupt flag in the next clock.
- R4: An unmasked parity fault sets the parity flag and the interrupt flag in the next clock. If both faults arrive together, both error flags are set.
- R5: A control write clears flags in the next clock. In the write data, bit 0 set clears the parity flag, bit 1 set clears the bus flag, and bit 2 set clears the interrupt flag. A bit that is 0 leaves its flag unchanged.
- R6: When a fault and a clear of the same flag arrive in the same clock, the mask is computed from the flags after the clear. The fault wins, and the flag ends up set.
- R7: When a fault is accepted in a data-ready clock, the supervisor-error flag takes the mode of the cycle that completes in that clock. When a fault is accepted one clock after a data-ready, it takes the mode of the cycle that completed in the previous clock. Outside this window the flag keeps its value.
- R8: Cycle modes are matched to data-ready strobes in issue order, with up to DEPTH cycles outstanding.
- R9: An external interrupt sets the interrupt flag and requests a trap only while the interrupt enable is 1. Bus and parity faults set the interrupt flag whatever the enable is.
- R10: The trap request is 1 in the clock after an accepted fault or an enabled interrupt, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_err_i | input | 1 | Bus fault reported for the current cycle |
| par_err_i | input | 1 | Parity fault reported by the data-check logic |
| cyc_issue_i | input | 1 | A memory cycle is issued this clock |
| cyc_super_i | input | 1 | Mode of the cycle being issued (1 = supervisor) |
| data_rdy_i | input | 1 | Data-ready strobe that completes the oldest outstanding cycle |
| ext_int_i | input | 1 | External interrupt line |
| int_en_i | input | 1 | External interrupt enable |
| ctl_wr_i | input | 1 | Control-register write strobe |
| ctl_wdata_i | input | 3 | Clear mask: bit 0 parity, bit 1 bus, bit 2 interrupt |
| par_flag_o | output | 1 | Parity error flag |
| bus_flag_o | output | 1 | Bus error flag |
| int_flag_o | output | 1 | Interrupt pending flag |
| sup_err_o | output | 1 | Mode of the faulting access (1 = supervisor) |
| trap_req_o | output | 1 | Trap request |

## Verification
The bench goes after the clock where a fault and a clear arrive together. A design that masks on the flags held before the clear would lose that fault and leave the flag cleared. It checks the capture window on both sides: on the data-ready clock, on the clock after it, and two clocks later. A design with the window off by one clock, or one that reads the cycle issued last instead of the oldest one, reports the wrong mode. It also checks that the interrupt enable gates only the external line. A design that gates all interrupt sources would drop the interrupt flag on a parity fault.

// File: rtl/etf_pkg.sv
package etf_pkg;

    localparam int CLR_W       = 3;
    localparam int CLR_PAR_BIT = 0;
    localparam int CLR_BUS_BIT = 1;
    localparam int CLR_INT_BIT = 2;

    typedef struct packed {
        logic clr_int;
        logic clr_bus;
        logic clr_par;
    } clr_req_t;

    typedef struct packed {
        logic hit;
        logic super_mode;
    } win_t;

    typedef struct packed {
        logic par;
        logic bus;
        logic intr;
        logic sup;
    } flag_state_t;

    function automatic clr_req_t decode_clear(input logic wr, input logic [CLR_W-1:0] d);
        clr_req_t c;
        c.clr_par = wr & d[CLR_PAR_BIT];
        c.clr_bus = wr & d[CLR_BUS_BIT];
        c.clr_int = wr & d[CLR_INT_BIT];
        return c;
    endfunction

    // A data-ready in the current clock takes priority over one in the previous clock.
    function automatic win_t pick_window(input logic rdy_now, input logic head_mode,
                                         input logic rdy_prev, input logic prev_mode);
        win_t w;
        w.hit        = rdy_now | rdy_prev;
        w.super_mode = rdy_now ? head_mode : prev_mode;
        return w;
    endfunction

endpackage

// File: rtl/etf_mode_track.sv
module etf_mode_track #(
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         issue_i,
    input  logic         issue_super_i,
    input  logic         rdy_i,
    output etf_pkg::win_t win_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] mode_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             prev_rdy_q, prev_mode_q;
    logic             head_mode;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_mode = mode_q[rd_ptr_q];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mode_q[g] <= 1'b0;
            else if (issue_i && wr_ptr_q == PTR_W'(g))
                mode_q[g] <= issue_super_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q    <= '0;
            rd_ptr_q    <= '0;
            count_q     <= '0;
            prev_rdy_q  <= 1'b0;
            prev_mode_q <= 1'b0;
        end else begin
            if (issue_i) wr_ptr_q <= bump(wr_ptr_q);
            if (rdy_i)   rd_ptr_q <= bump(rd_ptr_q);
            count_q     <= count_q + CNT_W'(issue_i) - CNT_W'(rdy_i);
            prev_rdy_q  <= rdy_i;
            prev_mode_q <= head_mode;
        end
    end

    assign win_o = etf_pkg::pick_window(rdy_i, head_mode, prev_rdy_q, prev_mode_q);

    // R8: the mode queue is never pushed past DEPTH or popped when empty
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        issue_i && !rdy_i |-> count_q != CNT_W'(DEPTH));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        rdy_i |-> count_q != '0);
    // R7: the window stays open for exactly one clock after a data-ready
    p_window_tail_r7: assert property (@(posedge clk) disable iff (rst)
        rdy_i |=> win_o.hit);

endmodule

// File: rtl/etf_flag_core.sv
module etf_flag_core (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_err_i,
    input  logic                  par_err_i,
    input  logic                  ext_int_i,
    input  logic                  int_en_i,
    input  etf_pkg::clr_req_t     clr_i,
    input  etf_pkg::win_t         win_i,
    output etf_pkg::flag_state_t  state_o,
    output logic                  trap_o
);
    logic par_q, bus_q, int_q, sup_q, trap_q;
    logic par_keep, bus_keep, masked;
    logic acc_bus, acc_par, acc_any, ext_hit;

    // The mask uses the flags as they stand after this clock's clear.
    assign par_keep = par_q & ~clr_i.clr_par;
    assign bus_keep = bus_q & ~clr_i.clr_bus;
    assign masked   = par_keep | bus_keep;
    assign acc_bus  = bus_err_i & ~masked;
    assign acc_par  = par_err_i & ~masked;
    assign acc_any  = acc_bus | acc_par;
    assign ext_hit  = ext_int_i & int_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_q  <= 1'b1;
            bus_q  <= 1'b1;
            int_q  <= 1'b0;
            sup_q  <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            par_q  <= par_keep | acc_par;
            bus_q  <= bus_keep | acc_bus;
            int_q  <= (int_q & ~clr_i.clr_int) | acc_any | ext_hit;
            trap_q <= acc_any | ext_hit;
            if (acc_any && win_i.hit)
                sup_q <= win_i.super_mode;
        end
    end

    assign state_o = '{par: par_q, bus: bus_q, intr: int_q, sup: sup_q};
    assign trap_o  = trap_q;

    p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (par_q || bus_q) && !clr_i.clr_par && !clr_i.clr_bus && !(ext_int_i && int_en_i)
        |=> !trap_q);
    p_bus_sets_r3: assert property (@(posedge clk) disable iff (rst)
        bus_err_i && !par_q && !bus_q |=> bus_q && int_q && trap_q);
    p_par_sets_r4: assert property (@(posedge clk) disable iff (rst)
        par_err_i && !par_q && !bus_q |=> par_q && int_q && trap_q);
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr_i.clr_par && !par_err_i |=> !par_q);
    p_err_beats_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr_i.clr_bus && clr_i.clr_par && bus_err_i |=> bus_q);
    p_sup_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !win_i.hit |=> $stable(sup_q));
    p_int_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ext_int_i && int_en_i |=> int_q && trap_q);

endmodule

// File: rtl/err_trap_flags.sv
module err_trap_flags #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_err_i,
    input  logic       par_err_i,
    input  logic       cyc_issue_i,
    input  logic       cyc_super_i,
    input  logic       data_rdy_i,
    input  logic       ext_int_i,
    input  logic       int_en_i,
    input  logic       ctl_wr_i,
    input  logic [2:0] ctl_wdata_i,
    output logic       par_flag_o,
    output logic       bus_flag_o,
    output logic       int_flag_o,
    output logic       sup_err_o,
    output logic       trap_req_o
);
    import etf_pkg::*;

    clr_req_t    clr;
    win_t        win;
    flag_state_t st;

    assign clr = decode_clear(ctl_wr_i, ctl_wdata_i);

    etf_mode_track #(.DEPTH(DEPTH)) u_track (
        .clk           (clk),
        .rst           (rst),
        .issue_i       (cyc_issue_i),
        .issue_super_i (cyc_super_i),
        .rdy_i         (data_rdy_i),
        .win_o         (win)
    );

    etf_flag_core u_core (
        .clk       (clk),
        .rst       (rst),
        .bus_err_i (bus_err_i),
        .par_err_i (par_err_i),
        .ext_int_i (ext_int_i),
        .int_en_i  (int_en_i),
        .clr_i     (clr),
        .win_i     (win),
        .state_o   (st),
        .trap_o    (trap_req_o)
    );

    assign par_flag_o = st.par;
    assign bus_flag_o = st.bus;
    assign int_flag_o = st.intr;
    assign sup_err_o  = st.sup;

    // R10: a trap request never comes without the interrupt flag set
    p_trap_implies_int_r10: assert property (@(posedge clk) disable iff (rst)
        trap_req_o |-> int_flag_o);

endmodule

// File: tb/err_trap_flags_tb_top.sv
module err_trap_flags_tb_top;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_err = 0, par_err = 0, issue = 0, super_m = 0, rdy = 0;
    logic ext_int = 0, int_en = 0, wr = 0;
    logic [2:0] wdata = '0;
    logic par_f, bus_f, int_f, sup_f, trap_f;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_par, m_bus, m_int, m_sup, m_trap, m_prev_rdy, m_prev_mode;
    bit mq[$];

    always #5 clk = ~clk;

    err_trap_flags #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bus_err_i(bus_err), .par_err_i(par_err),
        .cyc_issue_i(issue), .cyc_super_i(super_m), .data_rdy_i(rdy),
        .ext_int_i(ext_int), .int_en_i(int_en), .ctl_wr_i(wr), .ctl_wdata_i(wdata),
        .par_flag_o(par_f), .bus_flag_o(bus_f), .int_flag_o(int_f),
        .sup_err_o(sup_f), .trap_req_o(trap_f)
    );

    // Model built from the requirements, updated at each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_par = 1; m_bus = 1; m_int = 0; m_sup = 0; m_trap = 0;
            m_prev_rdy = 0; m_prev_mode = 0; mq.delete();
        end else begin
            bit pk, bk, msk, ab, ap, eh, wh, wm, cm;
            pk = m_par && !(wr && wdata[0]);
            bk = m_bus && !(wr && wdata[1]);
            msk = pk || bk;
            ab = bus_err && !msk;
            ap = par_err && !msk;
            eh = ext_int && int_en;
            cm = 0;
            if (rdy && mq.size() > 0) cm = mq.pop_front();
            wh = rdy || m_prev_rdy;
            wm = rdy ? cm : m_prev_mode;
            if ((ab || ap) && wh) m_sup = wm;
            m_int  = (m_int && !(wr && wdata[2])) || ab || ap || eh;
            m_trap = ab || ap || eh;
            m_par = pk || ap;
            m_bus = bk || ab;
            m_prev_rdy = rdy;
            m_prev_mode = cm;
            if (issue) mq.push_back(super_m);
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cmp_model(input string tag);
        chk({tag, " par"},  par_f,  m_par);
        chk({tag, " bus"},  bus_f,  m_bus);
        chk({tag, " int"},  int_f,  m_int);
        chk({tag, " sup"},  sup_f,  m_sup);
        chk({tag, " trap"}, trap_f, m_trap);
    endtask

    task automatic idle();
        bus_err = 0; par_err = 0; issue = 0; super_m = 0; rdy = 0;
        ext_int = 0; wr = 0; wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        idle();
        repeat (3) @(negedge clk);
        step();
        rst = 0;
        // R1 reset state
        chk("R1 par", par_f, 1); chk("R1 bus", bus_f, 1);
        chk("R1 int", int_f, 0); chk("R1 sup", sup_f, 0); chk("R1 trap", trap_f, 0);

        // R2 fault while masked
        bus_err = 1; par_err = 1; step(); idle();
        chk("R2 int", int_f, 0); chk("R2 trap", trap_f, 0);
        chk("R2 par", par_f, 1); chk("R2 bus", bus_f, 1);

        // R5 clear both error flags
        wr = 1; wdata = 3'b011; step(); idle();
        chk("R5 par", par_f, 0); chk("R5 bus", bus_f, 0);

        // R8 issue supervisor then user cycle
        issue = 1; super_m = 1; step();
        issue = 1; super_m = 0; step(); idle();
        // R3 and R7: bus fault on the data-ready clock of the supervisor cycle
        rdy = 1; bus_err = 1; step(); idle();
        chk("R3 bus", bus_f, 1); chk("R3 int", int_f, 1);
        chk("R7 sup same clock", sup_f, 1); chk("R3 par", par_f, 0);
        step();
        chk("R10 trap drops", trap_f, 0);

        // R4 and R7: parity fault one clock after data-ready of the user cycle
        wr = 1; wdata = 3'b111; step(); idle();
        chk("R5 int", int_f, 0);
        rdy = 1; step(); idle();
        par_err = 1; step(); idle();
        chk("R4 par", par_f, 1); chk("R4 int", int_f, 1); chk("R10 trap", trap_f, 1);
        chk("R8 sup oldest first", sup_f, 0);

        // R7 outside window: supervisor cycle completes, fault two clocks later
        wr = 1; wdata = 3'b111; issue = 1; super_m = 1; step(); idle();
        rdy = 1; step(); idle(); step();
        par_err = 1; step(); idle();
        chk("R7 sup held", sup_f, 0); chk("R4 par again", par_f, 1);

        // R6 fault and clear in the same clock
        wr = 1; wdata = 3'b011; bus_err = 1; step(); idle();
        chk("R6 bus", bus_f, 1); chk("R6 par", par_f, 0);

        // R4 both faults at once
        wr = 1; wdata = 3'b111; step(); idle();
        bus_err = 1; par_err = 1; step(); idle();
        chk("R4 both par", par_f, 1); chk("R4 both bus", bus_f, 1);

        // R9 interrupt enable gating
        wr = 1; wdata = 3'b111; step(); idle();
        ext_int = 1; int_en = 0; step(); idle();
        chk("R9 gated int", int_f, 0); chk("R9 gated trap", trap_f, 0);
        ext_int = 1; int_en = 1; step(); idle();
        chk("R9 enabled int", int_f, 1); chk("R9 enabled trap", trap_f, 1);
        wr = 1; wdata = 3'b100; int_en = 0; step(); idle();
        chk("R5 int clear", int_f, 0);
        par_err = 1; int_en = 0; step(); idle();
        chk("R9 parity ungated", int_f, 1);
        cmp_model("R8 directed end");

        // constrained random phase against the model
        for (int i = 0; i < 3000; i++) begin
            issue   = (mq.size() < DEPTH) && ($urandom_range(0, 9) < 4);
            super_m = $urandom_range(0, 1);
            rdy     = (mq.size() > 0) && ($urandom_range(0, 9) < 4);
            bus_err = ($urandom_range(0, 9) == 0);
            par_err = ($urandom_range(0, 9) == 0);
            ext_int = ($urandom_range(0, 9) == 0);
            int_en  = $urandom_range(0, 1);
            wr      = ($urandom_range(0, 99) < 15);
            wdata   = 3'($urandom_range(0, 7));
            step();
            cmp_model("R8 random");
        end
        idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule